// File: doc/BRIEF.md
# Two-Word Fetch and Branch Sequencer

This block steers program flow for a small 4-bit processor core. It keeps a 12-bit program counter, drives it as the read address of a byte-wide program memory whose data returns one clock later, and splits each fetched byte into an operation nibble (bits 7:4) and a modifier nibble (bits 3:0). From the operation nibble, and in one case the low modifier bit, it decides whether a second byte belongs to the instruction. Once an instruction is complete, it presents the instruction on a one-cycle decode strobe so the datapath can execute it.

The sequencer carries out the control-transfer instructions itself. These are long jumps, subroutine calls through a three-entry circular return stack, returns that also hand a data nibble to the accumulator, indirect jumps through a register pair that the datapath supplies, and conditional jumps within a 256-byte page. A conditional jump is taken or not according to a condition flag or a zero flag, which the datapath raises one cycle after the second byte has been decoded.

Top module: `fs_seq`

## Requirements
- R1: While reset is asserted and in the first cycle after it is released, `mem_addr` is 0, `dec_valid` and `acc_load_valid` are 0, and the return stack pointer is cleared with all entries holding 0. The first instruction decoded after reset is the byte at address 0.
- R2: For each instruction, `dec_valid` pulses for one cycle with `dec_word1` equal to the byte at the instruction's address. Two bytes are used by operation nibbles 0x1, 0x4, 0x5 and 0x7, and by nibble 0x2 when modifier bit 0 is 0. Every other byte is a single-word instruction.
- R3: For a two-word instruction, `dec_word2` holds the byte at the instruction address plus 1, with the address wrapping at 12 bits.
- R4: After any instruction that does not transfer control, the next instruction is decoded from the instruction address plus its length, modulo 4096.
- R5: Operation nibble 0x4 jumps to {word1[3:0], word2}.
- R6: Operation nibble 0x5 pushes the address that follows its second byte and jumps to {word1[3:0], word2}.
- R7: Operation nibble 0x1 samples `cond_true` in the cycle after its strobe. If the flag is 1, execution continues at {next[11:8], word2}, where next is the address after the instruction. Otherwise execution continues at next.
- R8: Operation nibble 0x7 behaves like R7 but samples `zero_flag` instead of `cond_true`.
- R9: Operation nibble 0xC pops the return stack and continues at the popped address. In the same cycle as its strobe, `acc_load_valid` is 1 and `acc_load_data` equals word1[3:0]. At all other times `acc_load_valid` is 0.
- R10: Operation nibble 0x3 with modifier bit 0 set continues at {next[11:8], pair_data}, where `pair_data` is sampled in the cycle of its strobe.
- R11: The stack is a circular buffer of three entries with a write pointer. A push writes at the pointer and advances it modulo 3, so a fourth push overwrites the oldest entry. A pop steps the pointer back modulo 3 and returns that entry, which is stale when the stack is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mem_rdata | input | 8 | Program memory data for the address presented one cycle earlier |
| cond_true | input | 1 | Condition result for a conditional page jump |
| zero_flag | input | 1 | Zero result of the register increment for a skip-style jump |
| pair_data | input | 8 | Register pair contents for an indirect jump |
| mem_addr | output | 12 | Program memory read address |
| dec_valid | output | 1 | One-cycle strobe marking a complete instruction |
| dec_word1 | output | 8 | First byte of the decoded instruction |
| dec_word2 | output | 8 | Second byte of a two-word instruction, 0 otherwise |
| acc_load_valid | output | 1 | Return instruction delivers a data nibble |
| acc_load_data | output | 4 | Nibble for the accumulator |

## Verification
The bench targets several corner cases. The first is the split of nibble 0x2 on modifier bit 0: a design that gets it wrong would take a following instruction as an operand, and every later word would be out of step. The second is a page-relative jump whose following address crosses a 256-byte boundary: a design that takes the page bits from the instruction address instead lands one page too low. The third is the flag timing: sampling the flag one cycle early picks up the wrong random value and takes or skips the branch at the wrong moment. The fourth is a call chain four deep followed by more returns than calls: a stack that saturates instead of wrapping, or that resets its pointer on underflow, returns to the wrong caller.

// File: rtl/fs_pkg.sv
package fs_pkg;

    localparam int NIB_W  = 4;
    localparam int WORD_W = 2 * NIB_W;
    localparam int ADDR_W = WORD_W + NIB_W;

    typedef enum logic [1:0] {
        ST_ISSUE = 2'd0,
        ST_OP1   = 2'd1,
        ST_OP2   = 2'd2,
        ST_COND  = 2'd3
    } seq_state_e;

    typedef enum logic [2:0] {
        K_PLAIN = 3'd0,
        K_CJMP  = 3'd1,
        K_IMM   = 3'd2,
        K_IND   = 3'd3,
        K_LJMP  = 3'd4,
        K_CALL  = 3'd5,
        K_ZJMP  = 3'd6,
        K_RET   = 3'd7
    } op_kind_e;

    localparam logic [NIB_W-1:0] OPN_CJMP = 4'h1;
    localparam logic [NIB_W-1:0] OPN_PAIR = 4'h2;
    localparam logic [NIB_W-1:0] OPN_IND  = 4'h3;
    localparam logic [NIB_W-1:0] OPN_LJMP = 4'h4;
    localparam logic [NIB_W-1:0] OPN_CALL = 4'h5;
    localparam logic [NIB_W-1:0] OPN_ZJMP = 4'h7;
    localparam logic [NIB_W-1:0] OPN_RET  = 4'hC;

endpackage

// File: rtl/fs_decode.sv
module fs_decode
    import fs_pkg::*;
(
    input  logic [WORD_W-1:0] word,
    output op_kind_e          kind,
    output logic              two_word
);

    logic [NIB_W-1:0] opn;
    logic             mod0;

    assign opn  = word[WORD_W-1 -: NIB_W];
    assign mod0 = word[0];

    always_comb begin
        kind     = K_PLAIN;
        two_word = 1'b0;
        unique case (opn)
            OPN_CJMP: begin kind = K_CJMP; two_word = 1'b1; end
            OPN_PAIR: begin
                if (!mod0) begin
                    kind     = K_IMM;
                    two_word = 1'b1;
                end
            end
            OPN_IND:  if (mod0) kind = K_IND;
            OPN_LJMP: begin kind = K_LJMP; two_word = 1'b1; end
            OPN_CALL: begin kind = K_CALL; two_word = 1'b1; end
            OPN_ZJMP: begin kind = K_ZJMP; two_word = 1'b1; end
            OPN_RET:  kind = K_RET;
            default:  kind = K_PLAIN;
        endcase
    end

endmodule

// File: rtl/fs_stack.sv
module fs_stack #(
    parameter int DEPTH = 3,
    parameter int AW    = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic          pop,
    input  logic [AW-1:0] push_val,
    output logic [AW-1:0] top_val
);

    localparam int          PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);

    logic [PW-1:0] ptr_d, ptr_q, prev_ptr;
    logic [AW-1:0] ent_d [DEPTH];
    logic [AW-1:0] ent_q [DEPTH];

    assign prev_ptr = (ptr_q == '0) ? LAST : ptr_q - 1'b1;
    assign top_val  = ent_q[prev_ptr];

    always_comb begin
        ptr_d = ptr_q;
        if (push)      ptr_d = (ptr_q == LAST) ? '0 : ptr_q + 1'b1;
        else if (pop)  ptr_d = prev_ptr;
    end

    for (genvar gi = 0; gi < DEPTH; gi++) begin : g_ent
        always_comb begin
            ent_d[gi] = ent_q[gi];
            if (push && (ptr_q == PW'(gi))) ent_d[gi] = push_val;
        end
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) ent_q[gi] <= '0;
            else        ent_q[gi] <= ent_d[gi];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ptr_q <= '0;
        else        ptr_q <= ptr_d;
    end

    AST_STACK_PTR_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        ptr_q <= LAST); // R11
    AST_PUSH_POP_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(push && pop)); // R11
    AST_PUSH_ADVANCES: assert property (@(posedge clk) disable iff (!rst_n)
        push |=> ptr_q != $past(ptr_q)); // R11

endmodule

// File: rtl/fs_seq.sv
module fs_seq
    import fs_pkg::*;
#(
    parameter int STACK_DEPTH = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [WORD_W-1:0] mem_rdata,
    input  logic              cond_true,
    input  logic              zero_flag,
    input  logic [WORD_W-1:0] pair_data,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              dec_valid,
    output logic [WORD_W-1:0] dec_word1,
    output logic [WORD_W-1:0] dec_word2,
    output logic              acc_load_valid,
    output logic [NIB_W-1:0]  acc_load_data
);

    localparam int PAGE_W = ADDR_W - WORD_W;

    typedef struct packed {
        seq_state_e        st;
        logic [ADDR_W-1:0] pc;
        logic [WORD_W-1:0] w1;
        logic [WORD_W-1:0] w2;
    } seq_regs_t;

    seq_regs_t r_d, r_q;

    op_kind_e          in_kind, hold_kind;
    logic              in_two, hold_two;
    logic              stk_push, stk_pop;
    logic [ADDR_W-1:0] stk_top;
    logic [ADDR_W-1:0] pc_inc;
    logic [ADDR_W-1:0] page_tgt;

    fs_decode u_dec_in (
        .word     (mem_rdata),
        .kind     (in_kind),
        .two_word (in_two)
    );

    fs_decode u_dec_hold (
        .word     (r_q.w1),
        .kind     (hold_kind),
        .two_word (hold_two)
    );

    fs_stack #(
        .DEPTH (STACK_DEPTH),
        .AW    (ADDR_W)
    ) u_stack (
        .clk      (clk),
        .rst_n    (rst_n),
        .push     (stk_push),
        .pop      (stk_pop),
        .push_val (r_q.pc),
        .top_val  (stk_top)
    );

    assign pc_inc   = r_q.pc + 1'b1;
    assign page_tgt = {r_q.pc[ADDR_W-1 -: PAGE_W], r_q.w2};

    always_comb begin
        r_d      = r_q;
        stk_push = 1'b0;
        stk_pop  = 1'b0;
        unique case (r_q.st)
            ST_ISSUE: begin
                r_d.pc = pc_inc;
                r_d.st = ST_OP1;
            end
            ST_OP1: begin
                r_d.w1 = mem_rdata;
                r_d.w2 = '0;
                if (in_two) begin
                    r_d.pc = pc_inc;
                    r_d.st = ST_OP2;
                end else if (in_kind == K_RET) begin
                    stk_pop = 1'b1;
                    r_d.pc  = stk_top;
                    r_d.st  = ST_ISSUE;
                end else if (in_kind == K_IND) begin
                    r_d.pc = {r_q.pc[ADDR_W-1 -: PAGE_W], pair_data};
                    r_d.st = ST_ISSUE;
                end else begin
                    r_d.pc = pc_inc;
                    r_d.st = ST_OP1;
                end
            end
            ST_OP2: begin
                r_d.w2 = mem_rdata;
                unique case (hold_kind)
                    K_LJMP: begin
                        r_d.pc = {r_q.w1[NIB_W-1:0], mem_rdata};
                        r_d.st = ST_ISSUE;
                    end
                    K_CALL: begin
                        stk_push = 1'b1;
                        r_d.pc   = {r_q.w1[NIB_W-1:0], mem_rdata};
                        r_d.st   = ST_ISSUE;
                    end
                    K_CJMP, K_ZJMP: begin
                        r_d.st = ST_COND;
                    end
                    default: begin
                        r_d.pc = pc_inc;
                        r_d.st = ST_OP1;
                    end
                endcase
            end
            ST_COND: begin
                if ((hold_kind == K_CJMP) ? cond_true : zero_flag)
                    r_d.pc = page_tgt;
                r_d.st = ST_ISSUE;
            end
            default: r_d.st = ST_ISSUE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.st <= ST_ISSUE;
            r_q.pc <= '0;
            r_q.w1 <= '0;
            r_q.w2 <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign mem_addr       = r_q.pc;
    assign dec_valid      = ((r_q.st == ST_OP1) && !in_two) || (r_q.st == ST_OP2);
    assign dec_word1      = (r_q.st == ST_OP1) ? mem_rdata : r_q.w1;
    assign dec_word2      = (r_q.st == ST_OP2) ? mem_rdata : '0;
    assign acc_load_valid = (r_q.st == ST_OP1) && (in_kind == K_RET);
    assign acc_load_data  = mem_rdata[NIB_W-1:0];

    AST_RESET_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> (mem_addr == '0) && !dec_valid); // R1
    AST_TWO_WORD_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_OP1) && in_two |=> mem_addr == $past(mem_addr) + 1'b1); // R3
    AST_LJMP_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
        dec_valid && (dec_word1[WORD_W-1 -: NIB_W] == OPN_LJMP)
        |=> mem_addr == {$past(dec_word1[NIB_W-1:0]), $past(dec_word2)}); // R5
    AST_CALL_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
        dec_valid && (dec_word1[WORD_W-1 -: NIB_W] == OPN_CALL)
        |=> mem_addr == {$past(dec_word1[NIB_W-1:0]), $past(dec_word2)}); // R6
    AST_ACC_ON_RET: assert property (@(posedge clk) disable iff (!rst_n)
        acc_load_valid |-> dec_valid && (dec_word1[WORD_W-1 -: NIB_W] == OPN_RET)); // R9
    AST_COND_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_OP2) && ((hold_kind == K_CJMP) || (hold_kind == K_ZJMP))
        |=> !dec_valid); // R7

endmodule

// File: tb/sim_fs_seq.sv
module sim_fs_seq;
    import fs_pkg::*;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [WORD_W-1:0] mem_rdata;
    logic              cond_true = 1'b0;
    logic              zero_flag = 1'b0;
    logic [WORD_W-1:0] pair_data = '0;
    logic [ADDR_W-1:0] mem_addr;
    logic              dec_valid;
    logic [WORD_W-1:0] dec_word1, dec_word2;
    logic              acc_load_valid;
    logic [NIB_W-1:0]  acc_load_data;

    always #10 clk = ~clk;

    fs_seq u0 (
        .clk            (clk),
        .rst_n          (rst_n),
        .mem_rdata      (mem_rdata),
        .cond_true      (cond_true),
        .zero_flag      (zero_flag),
        .pair_data      (pair_data),
        .mem_addr       (mem_addr),
        .dec_valid      (dec_valid),
        .dec_word1      (dec_word1),
        .dec_word2      (dec_word2),
        .acc_load_valid (acc_load_valid),
        .acc_load_data  (acc_load_data)
    );

    logic [WORD_W-1:0] mem [1 << ADDR_W];
    always_ff @(posedge clk) mem_rdata <= mem[mem_addr];

    int n_checks = 0;
    int n_fail   = 0;

    // reference state
    logic [ADDR_W-1:0] exp_pc;
    logic [ADDR_W-1:0] rstk [3];
    int                rptr;
    logic              pend;
    logic              pend_zero;
    logic [ADDR_W-1:0] pend_next;
    logic [WORD_W-1:0] pend_tgt;
    int                idle;

    task automatic check(input bit ok, input string req, input int act, input int expv);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
        end
    endtask

    function automatic bit is_two(input logic [7:0] b);
        case (b[7:4])
            4'h1, 4'h4, 4'h5, 4'h7: return 1'b1;
            4'h2:                   return !b[0];
            default:                return 1'b0;
        endcase
    endfunction

    function automatic logic [ADDR_W-1:0] page_join(input logic [ADDR_W-1:0] nx,
                                                   input logic [7:0] lo);
        return {nx[11:8], lo};
    endfunction

    task automatic model_reset();
        exp_pc = '0;
        rptr   = 0;
        for (int i = 0; i < 3; i++) rstk[i] = '0;
        pend   = 1'b0;
        idle   = 0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(mem_addr == '0, "R1 addr in reset", mem_addr, 0);
        check(!dec_valid && !acc_load_valid, "R1 strobes in reset", dec_valid, 0);
        rst_n = 1'b1;
        model_reset();
    endtask

    task automatic observe();
        logic [7:0]        b1, b2;
        logic [ADDR_W-1:0] nx;
        bit                tw;
        if (pend) begin
            check(!dec_valid, "R7 no strobe in flag cycle", dec_valid, 0);
            if (pend_zero)
                exp_pc = zero_flag ? page_join(pend_next, pend_tgt) : pend_next; // R8
            else
                exp_pc = cond_true ? page_join(pend_next, pend_tgt) : pend_next; // R7
            pend = 1'b0;
            idle = 0;
            return;
        end
        if (!dec_valid) begin
            check(!acc_load_valid, "R9 load without strobe", acc_load_valid, 0);
            idle++;
            return;
        end
        idle = 0;
        b1 = mem[exp_pc];
        b2 = mem[exp_pc + 1'b1];
        tw = is_two(b1);
        check(dec_word1 == b1, "R2 first word", dec_word1, b1);
        if (tw) begin
            check(dec_word2 == b2, "R3 second word", dec_word2, b2);
            nx = exp_pc + 12'd2;
        end else begin
            nx = exp_pc + 12'd1;
        end
        if (b1[7:4] == 4'hC) begin
            check(acc_load_valid && acc_load_data == b1[3:0], "R9 acc nibble",
                  {acc_load_valid, acc_load_data}, {1'b1, b1[3:0]});
        end else begin
            check(!acc_load_valid, "R9 load on non-return", acc_load_valid, 0);
        end
        case (b1[7:4])
            4'h4: exp_pc = {b1[3:0], b2};                      // R5
            4'h5: begin                                         // R6, R11
                rstk[rptr] = nx;
                rptr       = (rptr + 1) % 3;
                exp_pc     = {b1[3:0], b2};
            end
            4'hC: begin                                         // R9, R11
                rptr   = (rptr + 2) % 3;
                exp_pc = rstk[rptr];
            end
            4'h1, 4'h7: begin
                pend      = 1'b1;
                pend_zero = (b1[7:4] == 4'h7);
                pend_next = nx;
                pend_tgt  = b2;
            end
            4'h3: exp_pc = b1[0] ? page_join(nx, pair_data) : nx; // R10
            default: exp_pc = nx;                                 // R4
        endcase
    endtask

    task automatic run(input int cycles);
        for (int c = 0; c < cycles; c++) begin
            @(negedge clk);
            cond_true = 1'($urandom);
            zero_flag = 1'($urandom);
            pair_data = 8'($urandom);
            #1;
            observe();
            if (idle > 20) begin
                check(1'b0, "R2 watchdog no strobe", idle, 0);
                return;
            end
        end
    endtask

    initial begin
        void'($urandom(32'd4004));
        model_reset();
        for (int a = 0; a < (1 << ADDR_W); a++) mem[a] = 8'h00;
        // directed: page-crossing conditional jump then a call chain
        // four deep (overwrite) and returns past empty (stale entry)
        mem[12'h000] = 8'h40; mem[12'h001] = 8'hFE;
        mem[12'h0FE] = 8'h13; mem[12'h0FF] = 8'h40;
        mem[12'h100] = 8'h50; mem[12'h101] = 8'h10;
        mem[12'h140] = 8'h50; mem[12'h141] = 8'h10;
        mem[12'h010] = 8'h50; mem[12'h011] = 8'h20;
        mem[12'h020] = 8'h50; mem[12'h021] = 8'h30;
        mem[12'h030] = 8'h50; mem[12'h031] = 8'h40;
        mem[12'h040] = 8'hC1;
        mem[12'h032] = 8'hC2;
        mem[12'h022] = 8'h21; mem[12'h023] = 8'h20; mem[12'h024] = 8'h55;
        mem[12'h025] = 8'h3B; mem[12'h026] = 8'hC3;
        mem[12'h012] = 8'hC4;
        do_reset();
        run(400);
        // random programs, two passes with a reset between them
        for (int pass = 0; pass < 2; pass++) begin
            for (int a = 0; a < (1 << ADDR_W); a++) mem[a] = 8'($urandom);
            do_reset();
            run(20000);
        end
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        #(20 * 150000);
        n_fail++;
        $display("FAIL R2 global timeout actual=1 expected=0");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

endmodule